// File: doc/BRIEF.md
# Width-Configurable External Bus Request Generator

This block turns a request from a 32-bit core into an access on an external bus. The data width of the external bus is chosen per request: 8, 16 or 32 bits. The core gives a byte address, a byte mask, a direction, a beat count and a width code. The block then drives the following:

- a word-aligned address;
- a group of four byte-select pins;
- a one-clock start strobe;
- a direction line;
- data lanes steered for the chosen width.

On a narrow bus some of the byte-select pins carry low address bits instead of per-byte strobes.

An access may be a burst of up to four beats. The beats stay inside one 16-byte aligned block. Address bits 3:2 step on each beat and wrap within the block. The upper word bits stay fixed for the whole access. A beat ends when the ready input is sampled high in any cycle of the access, including the strobe cycle. Read data is shifted from the narrow lanes into its byte position in a 32-bit return word. Write data taken from the core is copied onto every lane that the narrow bus uses.

Top module: `xbus_req_gen`

## Requirements
- R1: While reset is held and after reset is released, both output enables (`bus_aoe`, `bus_doe`) are low. The strobe, the direction line, `beat_ack` and `done` are low, and `req_ready` is high.
- R2: `bus_ads` is high for exactly one clock, the clock after a request is accepted (`req_valid` and `req_ready` both high at an edge). It is low in every other cycle.
- R3: `bus_addr` is the request byte address shifted right by 2. On beat k (counted from 0), bits 1:0 of `bus_addr` equal (request address bits 3:2 plus k) modulo 4. The other bits of `bus_addr` never change during an access.
- R4: With width code 2 or 3 (32-bit), `bus_be` equals `req_mask`. Bit i enables data lane `[8i+7:8i]`.
- R5: With width code 1 (16-bit), let a1 be request address bit 1. `bus_be[3]` is the high-byte enable, `req_mask[2*a1+1]`. `bus_be[0]` is the low-byte enable, `req_mask[2*a1]`. `bus_be[1]` carries a1, and `bus_be[2]` is 0.
- R6: With width code 0 (8-bit), `bus_be[1:0]` carries request address bits 1:0 and `bus_be[3:2]` is 0.
- R7: `bus_doe` is high exactly during the cycles of a write access. `bus_dout` depends on the width:
  - 32-bit: `bus_dout` is `wr_data`.
  - 16-bit: both halves of `bus_dout` hold the `wr_data` halfword selected by address bit 1.
  - 8-bit: all four bytes of `bus_dout` hold the `wr_data` byte selected by address bits 1:0.
- R8: After each read beat, `rd_data` holds the beat's data, shifted into place and zero-filled:
  - 32-bit: `bus_din` unchanged.
  - 16-bit: `bus_din[15:0]` shifted left by 16 times address bit 1.
  - 8-bit: `bus_din[7:0]` shifted left by 8 times address bits 1:0.
- R9: `bus_wr` is 1 for writes and 0 for reads. It is set in the strobe cycle, holds for the whole access, and is 0 whenever no access is active.
- R10: A beat ends at a clock edge where `bus_rdy` is high during an access. `beat_ack` is high for the one following cycle. An access has `req_len`+1 beats. `done` pulses together with the last `beat_ack`, and `req_ready` is high again in that same cycle.
- R11: A request presented while `req_ready` is low is ignored. It raises no strobe, and it changes neither the address, the byte selects, the direction nor the beat count of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | 32 | Request byte address |
| req_mask | input | 4 | Byte mask within the word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Beats minus one |
| req_width | input | 2 | Width code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| wr_data | input | 32 | Write data for the current beat |
| rd_data | output | 32 | Aligned read data of the latest read beat |
| beat_ack | output | 1 | One-cycle pulse after each finished beat |
| done | output | 1 | One-cycle pulse after the final beat |
| bus_addr | output | 30 | Word address (byte address bits 31:2) |
| bus_be | output | 4 | Byte selects or low address bits, depending on width |
| bus_ads | output | 1 | Start-of-access strobe |
| bus_wr | output | 1 | Direction, 1 = write |
| bus_aoe | output | 1 | Output enable for address and byte selects |
| bus_dout | output | 32 | Steered write lanes |
| bus_doe | output | 1 | Output enable for write lanes |
| bus_din | input | 32 | Read lanes from the bus |
| bus_rdy | input | 1 | Beat ready |

## Verification
The bench builds the block with its default parameters: a 32-bit address, four byte lanes, a 2-bit beat counter and narrow widths enabled. The 2-bit beat counter keeps the full set of combinations small enough to sweep in full:

- every width code;
- every byte offset;
- both directions;
- every burst length.

The start words are chosen so that bursts wrap address bits 3:2 from 3 back to 0. A further sweep covers all sixteen masks at every offset on the 16- and 32-bit widths. Ready is held off for a varying number of cycles, so that zero-wait beats and beats with wait states both occur.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [1:0] {
      BW8      = 2'd0,
      BW16     = 2'd1,
      BW32     = 2'd2,
      BW32_ALT = 2'd3
   } bus_width_e;

   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_ACCESS = 1'b1
   } seq_state_e;

   localparam int unsigned XB_LANES  = 4;
   localparam int unsigned XB_LANE_W = 8;

endpackage

// File: rtl/xbus_addr_seq.sv
module xbus_addr_seq #(
   parameter int unsigned WORD_W = 30,
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic [WORD_W-1:0] base_word,
   output logic [WORD_W-1:0] word_addr,
   output logic [BEAT_W-1:0] beat_idx
);

   generate
      if (BEAT_W < 1 || WORD_W <= BEAT_W) begin : g_bad_cfg
         $error("xbus_addr_seq: WORD_W must exceed BEAT_W >= 1");
      end
   endgenerate

   logic [WORD_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] low_sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
      end else if (load) begin
         base_q <= base_word;
         beat_q <= '0;
      end else if (adv) begin
         beat_q <= beat_q + 1'b1;
      end
   end

   // wrap inside the aligned block: no carry out of the low field
   assign low_sum   = base_q[BEAT_W-1:0] + beat_q;
   assign word_addr = {base_q[WORD_W-1:BEAT_W], low_sum};
   assign beat_idx  = beat_q;

   p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> $stable(word_addr[WORD_W-1:BEAT_W]));

   p_low_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=>
      ((word_addr[BEAT_W-1:0] - $past(word_addr[BEAT_W-1:0])) == BEAT_W'(1)));

   p_load_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (word_addr == $past(base_word)));

endmodule

// File: rtl/xbus_lane_enc.sv
module xbus_lane_enc
   import xbus_pkg::*;
#(
   parameter bit NARROW_EN = 1'b1
) (
   input  bus_width_e              width,
   input  logic [1:0]              offset,
   input  logic [XB_LANES-1:0]     mask,
   output logic [XB_LANES-1:0]     sel
);

   generate
      if (XB_LANES != 4) begin : g_bad_lanes
         $error("xbus_lane_enc: four byte lanes required");
      end

      if (NARROW_EN) begin : g_multi
         always_comb begin
            sel = '0;
            case (width)
               BW8: begin
                  sel[1] = offset[1];
                  sel[0] = offset[0];
               end
               BW16: begin
                  sel[3] = offset[1] ? mask[3] : mask[1];
                  sel[1] = offset[1];
                  sel[0] = offset[1] ? mask[2] : mask[0];
               end
               default: sel = mask;
            endcase
         end
      end else begin : g_wide_only
         assign sel = mask;
      end
   endgenerate

endmodule

// File: rtl/xbus_data_steer.sv
module xbus_data_steer
   import xbus_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  bus_width_e        width,
   input  logic [1:0]        offset,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic [DATA_W-1:0] lanes_in,
   output logic [DATA_W-1:0] lanes_out,
   output logic [DATA_W-1:0] core_rdata
);

   localparam int unsigned NB = DATA_W / XB_LANE_W;

   generate
      if (NB != XB_LANES || (DATA_W % XB_LANE_W) != 0) begin : g_bad_width
         $error("xbus_data_steer: DATA_W must hold exactly four byte lanes");
      end
   endgenerate

   logic [XB_LANE_W-1:0] wr_b [NB];
   logic [XB_LANE_W-1:0] in_b [NB];

   for (genvar j = 0; j < NB; j++) begin : g_split
      assign wr_b[j] = core_wdata[XB_LANE_W*j +: XB_LANE_W];
      assign in_b[j] = lanes_in[XB_LANE_W*j +: XB_LANE_W];
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      localparam logic     LO_BIT = 1'(i % 2);
      localparam logic     HI_BIT = 1'(i / 2);
      localparam logic [1:0] IDX  = 2'(i);

      // outgoing lane: copy the selected unit onto every lane
      always_comb begin
         case (width)
            BW8:     lanes_out[XB_LANE_W*i +: XB_LANE_W] = wr_b[offset];
            BW16:    lanes_out[XB_LANE_W*i +: XB_LANE_W] = wr_b[{offset[1], LO_BIT}];
            default: lanes_out[XB_LANE_W*i +: XB_LANE_W] = wr_b[IDX];
         endcase
      end

      // returned byte: place narrow lanes at their address position
      always_comb begin
         case (width)
            BW8:     core_rdata[XB_LANE_W*i +: XB_LANE_W] =
                        (offset == IDX) ? in_b[0] : '0;
            BW16:    core_rdata[XB_LANE_W*i +: XB_LANE_W] =
                        (offset[1] == HI_BIT) ? in_b[{1'b0, LO_BIT}] : '0;
            default: core_rdata[XB_LANE_W*i +: XB_LANE_W] = in_b[IDX];
         endcase
      end
   end

endmodule

// File: rtl/xbus_req_gen.sv
module xbus_req_gen
   import xbus_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEN_W     = 2,
   parameter bit          NARROW_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [XB_LANES-1:0]  req_mask,
   input  logic                 req_write,
   input  logic [LEN_W-1:0]     req_len,
   input  logic [1:0]           req_width,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 beat_ack,
   output logic                 done,
   output logic [ADDR_W-3:0]    bus_addr,
   output logic [XB_LANES-1:0]  bus_be,
   output logic                 bus_ads,
   output logic                 bus_wr,
   output logic                 bus_aoe,
   output logic [DATA_W-1:0]    bus_dout,
   output logic                 bus_doe,
   input  logic [DATA_W-1:0]    bus_din,
   input  logic                 bus_rdy
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   generate
      if (DATA_W != XB_LANES * XB_LANE_W) begin : g_bad_dw
         $error("xbus_req_gen: DATA_W must be 32");
      end
      if (LEN_W < 1 || LEN_W + 2 >= ADDR_W) begin : g_bad_len
         $error("xbus_req_gen: LEN_W out of range");
      end
   endgenerate

   seq_state_e        state_q;
   bus_width_e        width_q;
   bus_width_e        width_in;
   logic [1:0]        off_q;
   logic [XB_LANES-1:0] mask_q;
   logic [LEN_W-1:0]  len_q;
   logic              wr_q;
   logic              ads_q;
   logic              ack_q;
   logic              done_q;
   logic [DATA_W-1:0] rd_q;

   logic              accept;
   logic              beat_end;
   logic              last_beat;
   logic [LEN_W-1:0]  beat_idx;
   logic [WORD_W-1:0] word_addr;
   logic [DATA_W-1:0] rd_aligned;

   generate
      if (NARROW_EN) begin : g_width_sel
         assign width_in = bus_width_e'(req_width);
      end else begin : g_width_fixed
         assign width_in = BW32;
      end
   endgenerate

   assign accept    = (state_q == ST_IDLE) && req_valid;
   assign beat_end  = (state_q == ST_ACCESS) && bus_rdy;
   assign last_beat = (beat_idx == len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         width_q <= BW32;
         off_q   <= '0;
         mask_q  <= '0;
         len_q   <= '0;
         wr_q    <= 1'b0;
         ads_q   <= 1'b0;
         ack_q   <= 1'b0;
         done_q  <= 1'b0;
         rd_q    <= '0;
      end else begin
         ads_q  <= accept;
         ack_q  <= beat_end;
         done_q <= beat_end && last_beat;
         if (accept) begin
            state_q <= ST_ACCESS;
            width_q <= width_in;
            off_q   <= req_addr[1:0];
            mask_q  <= req_mask;
            len_q   <= req_len;
            wr_q    <= req_write;
         end else if (beat_end && last_beat) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
         end
         if (beat_end && !wr_q) begin
            rd_q <= rd_aligned;
         end
      end
   end

   xbus_addr_seq #(
      .WORD_W (WORD_W),
      .BEAT_W (LEN_W)
   ) addr_seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .adv       (beat_end && !last_beat),
      .base_word (req_addr[ADDR_W-1:2]),
      .word_addr (word_addr),
      .beat_idx  (beat_idx)
   );

   xbus_lane_enc #(
      .NARROW_EN (NARROW_EN)
   ) lane_enc_i (
      .width  (width_q),
      .offset (off_q),
      .mask   (mask_q),
      .sel    (bus_be)
   );

   xbus_data_steer #(
      .DATA_W (DATA_W)
   ) data_steer_i (
      .width      (width_q),
      .offset     (off_q),
      .core_wdata (wr_data),
      .lanes_in   (bus_din),
      .lanes_out  (bus_dout),
      .core_rdata (rd_aligned)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign bus_addr  = word_addr;
   assign bus_ads   = ads_q;
   assign bus_wr    = wr_q;
   assign bus_aoe   = (state_q == ST_ACCESS);
   assign bus_doe   = (state_q == ST_ACCESS) && wr_q;
   assign rd_data   = rd_q;
   assign beat_ack  = ack_q;
   assign done      = done_q;

   p_ads_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ads |=> !bus_ads);

   p_ads_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ads |-> (bus_aoe && $past(req_valid && req_ready)));

   p_wr_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_aoe && !bus_ads) |-> $stable(bus_wr));

   p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_aoe |-> !bus_wr);

   p_doe_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> (bus_wr && bus_aoe));

   p_ack_needs_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      beat_ack |-> $past(bus_rdy && bus_aoe));

   p_done_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (beat_ack && req_ready));

   p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> !bus_ads);

endmodule

// File: tb/xbus_req_gen_tb_top.sv
module xbus_req_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_addr;
   logic [3:0]  req_mask;
   logic        req_write;
   logic [1:0]  req_len;
   logic [1:0]  req_width;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic        beat_ack;
   logic        done;
   logic [29:0] bus_addr;
   logic [3:0]  bus_be;
   logic        bus_ads;
   logic        bus_wr;
   logic        bus_aoe;
   logic [31:0] bus_dout;
   logic        bus_doe;
   logic [31:0] bus_din;
   logic        bus_rdy;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   xbus_req_gen dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr),
      .req_mask  (req_mask),
      .req_write (req_write),
      .req_len   (req_len),
      .req_width (req_width),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .beat_ack  (beat_ack),
      .done      (done),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_ads   (bus_ads),
      .bus_wr    (bus_wr),
      .bus_aoe   (bus_aoe),
      .bus_dout  (bus_dout),
      .bus_doe   (bus_doe),
      .bus_din   (bus_din),
      .bus_rdy   (bus_rdy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] exp_be(input int w, input int off, input logic [3:0] m);
      logic [1:0] o = 2'(off);
      if (w == 0) return {2'b00, o};
      if (w == 1) return {m[2*o[1]+1], 1'b0, o[1], m[2*o[1]]};
      return m;
   endfunction

   function automatic logic [31:0] exp_dout(input int w, input int off, input logic [31:0] d);
      logic [1:0] o = 2'(off);
      if (w == 0) return {4{d[8*o +: 8]}};
      if (w == 1) return {2{d[16*o[1] +: 16]}};
      return d;
   endfunction

   function automatic logic [31:0] exp_rd(input int w, input int off, input logic [31:0] d);
      logic [1:0] o = 2'(off);
      if (w == 0) return {24'h0, d[7:0]} << (8 * o);
      if (w == 1) return {16'h0, d[15:0]} << (16 * o[1]);
      return d;
   endfunction

   function automatic string be_tag(input int w);
      if (w == 0) return "R6";
      if (w == 1) return "R5";
      return "R4";
   endfunction

   task automatic run_req(input int w, input int off, input bit wr, input int len,
                          input logic [3:0] m, input logic [29:0] word, input bit hold);
      logic [31:0] wp;
      logic [31:0] rp;
      logic [29:0] ea;
      int waits;
      chk("R10 ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1;
      req_width = 2'(w);
      req_addr  = {word, 2'(off)};
      req_mask  = m;
      req_write = wr;
      req_len   = 2'(len);
      @(posedge clk);
      @(negedge clk);
      if (hold) begin
         req_addr  = ~req_addr;
         req_mask  = ~m;
         req_write = ~wr;
         req_len   = ~req_len;
         req_width = 2'(w) ^ 2'b01;
      end else begin
         req_valid = 1'b0;
      end
      for (int k = 0; k <= len; k++) begin
         wp = 32'hA1B2C3D4 ^ (32'(k) * 32'h01010101);
         rp = 32'h5E6F7081 + (32'(k) * 32'h11111111);
         wr_data = wp;
         bus_din = rp;
         waits = (k + off + len + w) % 3;
         ea = {word[29:2], 2'(word[1:0] + 2'(k))};
         for (int c = 0; c <= waits; c++) begin
            #1;
            chk((hold && !(k == 0 && c == 0)) ? "R11 strobe while busy" : "R2 strobe",
                32'(bus_ads), 32'(k == 0 && c == 0));
            chk(hold ? "R11 address" : "R3 address", 32'(bus_addr), 32'(ea));
            chk(hold ? "R11 byte selects" : be_tag(w), 32'(bus_be), 32'(exp_be(w, off, m)));
            chk(hold ? "R11 direction" : "R9 direction", 32'(bus_wr), 32'(wr));
            chk("R7 data enable", 32'(bus_doe), 32'(wr));
            chk("R1 address enable in access", 32'(bus_aoe), 32'd1);
            if (wr) chk("R7 write lanes", bus_dout, exp_dout(w, off, wp));
            if (!(c == 0 && k > 0)) chk("R10 no ack mid beat", 32'(beat_ack), 32'd0);
            bus_rdy = (c == waits);
            @(posedge clk);
            @(negedge clk);
         end
         bus_rdy = 1'b0;
         if (hold && k == len) req_valid = 1'b0;
         #1;
         chk("R10 beat ack", 32'(beat_ack), 32'd1);
         chk(hold ? "R11 beat count" : "R10 done timing", 32'(done), 32'(k == len));
         if (!wr) chk("R8 read alignment", rd_data, exp_rd(w, off, rp));
      end
      chk("R10 ready after done", 32'(req_ready), 32'd1);
      chk("R9 idle direction", 32'(bus_wr), 32'd0);
      chk("R7 idle data enable", 32'(bus_doe), 32'd0);
      @(negedge clk);
      #1;
      chk("R10 done single pulse", 32'(done), 32'd0);
      chk("R2 no strobe when idle", 32'(bus_ads), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_addr  = '0;
      req_mask  = '0;
      req_write = 1'b0;
      req_len   = '0;
      req_width = '0;
      wr_data   = '0;
      bus_din   = '0;
      bus_rdy   = 1'b0;
      repeat (3) @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         chk("R1 address enable", 32'(bus_aoe), 32'd0);
         chk("R1 data enable", 32'(bus_doe), 32'd0);
         chk("R1 strobe", 32'(bus_ads), 32'd0);
         chk("R1 direction", 32'(bus_wr), 32'd0);
         chk("R1 ready", 32'(req_ready), 32'd1);
         chk("R1 done", 32'(done), 32'd0);
         chk("R1 ack", 32'(beat_ack), 32'd0);
         rst_n = 1'b1;
         @(negedge clk);
      end

      for (int w = 0; w < 4; w++)
         for (int off = 0; off < 4; off++)
            for (int wr = 0; wr < 2; wr++)
               for (int len = 0; len < 4; len++) begin
                  int seed = ((w * 4 + off) * 2 + wr) * 4 + len;
                  run_req(w, off, 1'(wr), len, 4'((seed * 7 + 3) % 16),
                          {28'(32'h0ABC_0001 * (seed + 1)), 2'(seed)}, 1'b0);
               end

      for (int w = 1; w < 3; w++)
         for (int m = 0; m < 16; m++)
            for (int off = 0; off < 4; off++)
               run_req(w, off, 1'b0, 0, 4'(m), {28'(m * 977 + off), 2'(m)}, 1'b0);

      run_req(0, 3, 1'b1, 3, 4'b1010, 30'h1234_5672, 1'b1);
      run_req(2, 1, 1'b0, 2, 4'b0110, 30'h0765_4323, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule